// File: doc/BRIEF.md
# Photon Trigger Threshold Combiner

This block merges the first-photon hit lines of the four sub-arrays of a photon-counting pixel into one master trigger. The master trigger starts a time-to-digital measurement. A two-bit level select chooses how many sub-arrays must report a hit before the trigger fires. Each threshold above the lowest is a fixed OR/AND combination of the four lines. The result is therefore a statistical photon threshold, not an exact count: two photons that land on the same sub-array raise only one line.

Each hit line stays high while its sub-array holds a pending breakdown. Each sub-array has its own refresh timer. If a breakdown does not lead to a master trigger within a programmable number of clock cycles, the timer emits a refresh pulse that clears it. This stops isolated dark counts from piling up toward the threshold. At the lowest level any single hit fires the trigger at once, so no refresh ever happens there.

The master trigger is registered. Once it fires it stays high, and all timers are frozen, until the synchronous reset marks the end of the acquisition.

Top module: `photon_trig_combiner`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `mtrig` is 0 and `refresh` is 4'b0000.
- R2: With `lvl_sel` = 2'b00, one edge after any bit of `sub_hit` is high, `mtrig` becomes 1. Bit i of `sub_hit` is sub-array i.
- R3: With `lvl_sel` = 2'b01, `mtrig` becomes 1 one edge after (sub_hit[0] | sub_hit[1]) & (sub_hit[2] | sub_hit[3]) is true. Otherwise it stays 0.
- R4: With `lvl_sel` = 2'b10, `mtrig` becomes 1 one edge after (sub_hit[0] | sub_hit[1]) & sub_hit[2] & sub_hit[3] is true. Otherwise it stays 0.
- R5: With `lvl_sel` = 2'b11, `mtrig` becomes 1 one edge after all four `sub_hit` bits are high. Otherwise it stays 0.
- R6: Once set, `mtrig` stays 1 whatever `sub_hit` and `lvl_sel` do, until `rst` clears it.
- R7: While idle, a line `sub_hit[i]` held high for `win_len` consecutive clock edges makes `refresh[i]` high for one cycle after the `win_len`-th edge. The timer then restarts if the line is still high. Each sub-array is timed on its own.
- R8: No refresh pulse is issued while `mtrig` is 1. None is issued on the edge that sets `mtrig`.
- R9: A `win_len` of 0 disables refresh entirely.
- R10: `lvl_sel` is captured during reset and on every idle edge. Its value while `mtrig` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also ends an acquisition |
| sub_hit | input | 4 | Pending-breakdown line of each sub-array |
| lvl_sel | input | 2 | Trigger level: 00 any, 01 two, 10 three, 11 four |
| win_len | input | WIN_W | Refresh window in clock cycles, 0 disables refresh |
| mtrig | output | 1 | Registered, sticky master trigger |
| refresh | output | 4 | One-cycle clear pulse per sub-array |

## Verification
The bench uses the default window width of 8 bits and drives short windows of 2, 3 and 5 cycles. These short windows bring several cases within a few dozen cycles: a timer expiring, a timer restarting on a line that stays high, two offset timers running side by side, and a refresh colliding with a trigger on the same edge. A window of 0 exercises the disabled case. The hit patterns are chosen to separate the four OR/AND levels from one another.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int N_SUB = 4;

  typedef enum logic [1:0] {
    LVL_ANY   = 2'b00,
    LVL_TWO   = 2'b01,
    LVL_THREE = 2'b10,
    LVL_FOUR  = 2'b11
  } trig_lvl_e;
endpackage

// File: rtl/ptc_level_logic.sv
module ptc_level_logic
  import ptc_pkg::*;
(
  input  trig_lvl_e        lvl,
  input  logic [N_SUB-1:0] hit,
  output logic             fire
);
  logic pair_lo, pair_hi;

  assign pair_lo = hit[0] | hit[1];
  assign pair_hi = hit[2] | hit[3];

  always_comb begin
    unique case (lvl)
      LVL_ANY:   fire = |hit;
      LVL_TWO:   fire = pair_lo & pair_hi;
      LVL_THREE: fire = pair_lo & hit[2] & hit[3];
      LVL_FOUR:  fire = &hit;
      default:   fire = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptc_refresh_timer.sv
module ptc_refresh_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             freeze,
  input  logic [WIN_W-1:0] win_len,
  output logic             refresh
);
  logic [WIN_W-1:0] cnt_q;
  logic             refresh_q;
  logic             expire;

  assign expire = (win_len != '0) && (cnt_q == win_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else if (freeze) begin
      refresh_q <= 1'b0;
    end else if (!hit) begin
      cnt_q     <= '0;
      refresh_q <= 1'b0;
    end else if (expire) begin
      cnt_q     <= '0;
      refresh_q <= 1'b1;
    end else begin
      cnt_q     <= cnt_q + 1'b1;
      refresh_q <= 1'b0;
    end
  end

  assign refresh = refresh_q;
endmodule

// File: rtl/photon_trig_combiner.sv
module photon_trig_combiner
  import ptc_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       sub_hit,
  input  logic [1:0]       lvl_sel,
  input  logic [WIN_W-1:0] win_len,
  output logic             mtrig,
  output logic [3:0]       refresh
);
  trig_lvl_e lvl_q;
  logic      mtrig_q;
  logic      lvl_fire;
  logic      trig_now;
  logic      freeze;

  ptc_level_logic u_level (
    .lvl  (lvl_q),
    .hit  (sub_hit),
    .fire (lvl_fire)
  );

  assign trig_now = !mtrig_q && lvl_fire;
  assign freeze   = mtrig_q | trig_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      mtrig_q <= 1'b0;
      lvl_q   <= trig_lvl_e'(lvl_sel);
    end else begin
      if (trig_now) mtrig_q <= 1'b1;
      if (!mtrig_q) lvl_q   <= trig_lvl_e'(lvl_sel);
    end
  end

  for (genvar i = 0; i < N_SUB; i++) begin : g_timer
    ptc_refresh_timer #(.WIN_W(WIN_W)) u_timer (
      .clk     (clk),
      .rst     (rst),
      .hit     (sub_hit[i]),
      .freeze  (freeze),
      .win_len (win_len),
      .refresh (refresh[i])
    );
  end

  assign mtrig = mtrig_q;
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker (
  input logic       clk,
  input logic       rst,
  input logic [3:0] sub_hit,
  input logic [1:0] lvl_q,
  input logic       mtrig,
  input logic [3:0] refresh
);
  // R6: trigger is sticky
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    mtrig |=> mtrig);

  // R6: trigger only falls through reset
  p_fall_rst_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(mtrig) |-> $past(rst));

  // R8: no refresh while triggered
  p_no_rfr_trig_r8: assert property (@(posedge clk) disable iff (rst)
    mtrig |-> (refresh == 4'b0000));

  // R7: a refresh pulse needs a pending line
  p_rfr_needs_hit_r7: assert property (@(posedge clk) disable iff (rst)
    (refresh != 4'b0000) |-> (($past(sub_hit) & refresh) == refresh));

  // R2: a trigger needs at least one line
  p_trig_needs_hit_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(mtrig) |-> ($past(sub_hit) != 4'b0000));

  // R5: four-line level needs all lines
  p_four_all_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(mtrig) && ($past(lvl_q) == 2'b11)) |-> ($past(sub_hit) == 4'b1111));
endmodule

bind photon_trig_combiner ptc_checker u_ptc_checker (
  .clk     (clk),
  .rst     (rst),
  .sub_hit (sub_hit),
  .lvl_q   (lvl_q),
  .mtrig   (mtrig),
  .refresh (refresh)
);

// File: tb/photon_trig_combiner_bench.sv
module photon_trig_combiner_bench;
  localparam int WIN_W = 8;
  localparam int NVEC  = 16;

  // {lvl_sel[1:0], sub_hit[3:0], expected mtrig}
  localparam logic [6:0] VEC [NVEC] = '{
    {2'b00, 4'b0000, 1'b0}, {2'b00, 4'b0001, 1'b1},
    {2'b00, 4'b1000, 1'b1}, {2'b00, 4'b0110, 1'b1},
    {2'b01, 4'b0011, 1'b0}, {2'b01, 4'b1100, 1'b0},
    {2'b01, 4'b0101, 1'b1}, {2'b01, 4'b1010, 1'b1},
    {2'b10, 4'b1100, 1'b0}, {2'b10, 4'b1101, 1'b1},
    {2'b10, 4'b1110, 1'b1}, {2'b10, 4'b0111, 1'b0},
    {2'b11, 4'b1111, 1'b1}, {2'b11, 4'b1110, 1'b0},
    {2'b11, 4'b0111, 1'b0}, {2'b11, 4'b1011, 1'b0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       sub_hit = '0;
  logic [1:0]       lvl_sel = '0;
  logic [WIN_W-1:0] win_len = '0;
  logic             mtrig;
  logic [3:0]       refresh;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  photon_trig_combiner #(.WIN_W(WIN_W)) u_photon_trig_combiner (
    .clk     (clk),
    .rst     (rst),
    .sub_hit (sub_hit),
    .lvl_sel (lvl_sel),
    .win_len (win_len),
    .mtrig   (mtrig),
    .refresh (refresh)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] lvl, input logic [WIN_W-1:0] w);
    @(negedge clk);
    rst = 1'b1; sub_hit = '0; lvl_sel = lvl; win_len = w;
    tick();
    rst = 1'b0;
  endtask

  function automatic string lvl_req(input logic [1:0] l);
    case (l)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #80000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset(2'b00, 8'd0);
    check("R1 mtrig in reset", {7'd0, mtrig}, 8'd0);
    check("R1 refresh in reset", {4'd0, refresh}, 8'd0);
    tick();
    check("R1 mtrig after reset", {7'd0, mtrig}, 8'd0);

    // table walk, refresh disabled
    for (int v = 0; v < NVEC; v++) begin
      do_reset(VEC[v][6:5], 8'd0);
      sub_hit = VEC[v][4:1];
      tick();
      check(lvl_req(VEC[v][6:5]), {7'd0, mtrig}, {7'd0, VEC[v][0]});
    end

    // R6 and R10: sticky trigger, lvl_sel ignored while triggered
    do_reset(2'b01, 8'd0);
    sub_hit = 4'b1001;
    tick();
    check("R6 set", {7'd0, mtrig}, 8'd1);
    sub_hit = 4'b0000; lvl_sel = 2'b11;
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R6 held", {7'd0, mtrig}, 8'd1);
    end
    rst = 1'b1;
    tick();
    check("R6 cleared by rst", {7'd0, mtrig}, 8'd0);
    rst = 1'b0;
    sub_hit = 4'b0111;
    tick();
    check("R10 level 11 captured at reset", {7'd0, mtrig}, 8'd0);

    // R7: two offset timers, window 5, restart on held line
    do_reset(2'b11, 8'd5);
    sub_hit = 4'b0001;
    for (int k = 1; k <= 10; k++) begin
      tick();
      if (k == 2) sub_hit[1] = 1'b1;
      check("R7 refresh timing", {4'd0, refresh},
            {4'd0, 2'b00, (k == 7), (k == 5 || k == 10)});
      check("R7 no trigger", {7'd0, mtrig}, 8'd0);
    end
    sub_hit = '0;

    // R8: refresh due on the trigger edge is dropped, then frozen
    do_reset(2'b01, 8'd2);
    sub_hit = 4'b0001;
    tick();
    check("R8 idle", {4'd0, refresh}, 8'd0);
    sub_hit = 4'b0101;
    tick();
    check("R8 trigger", {7'd0, mtrig}, 8'd1);
    check("R8 no refresh on trigger edge", {4'd0, refresh}, 8'd0);
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R8 frozen", {4'd0, refresh}, 8'd0);
    end

    // R8 with longer window: expiry after trigger suppressed
    do_reset(2'b10, 8'd3);
    sub_hit = 4'b0100;
    tick();
    sub_hit = 4'b1110;
    tick();
    check("R8 trigger level 10", {7'd0, mtrig}, 8'd1);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R8 no refresh after trigger", {4'd0, refresh}, 8'd0);
    end

    // R9: window 0 never refreshes
    do_reset(2'b11, 8'd0);
    sub_hit = 4'b0011;
    for (int k = 0; k < 20; k++) begin
      tick();
      check("R9 disabled", {4'd0, refresh}, 8'd0);
    end
    sub_hit = '0;

    // R7: window 1 pulses every edge on a held line
    do_reset(2'b11, 8'd1);
    sub_hit = 4'b1000;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R7 window 1", {4'd0, refresh}, 8'h08);
    end
    sub_hit = '0;
    tick();
    check("R7 line dropped", {4'd0, refresh}, 8'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule